// File: doc/BRIEF.md
# Programmable 16-bit Timer/Counter

This block is a 16-bit down-counter with a start value that software loads one byte at a time. The low byte is written first and held in a latch. Writing the high byte moves both bytes into the counter and starts the count. The count runs in one of three modes. In one-shot mode it times out a single time. In free-running mode it reloads from the latch and keeps dividing the clock. In pulse-counting mode it decrements only on falling edges of an external input.

On each time-out the block can raise an interrupt flag, which software clears with a dedicated input. A waveform output gives one of two shapes. In one-shot and pulse-counting modes it is a single low pulse that lasts from the load to the time-out. In free-running mode it is a square wave whose half period is one full count.

Top module: `tmr16_counter`

## Requirements
- R1: After reset, irq_flag is 0 and wave_out is 1. Until the first high-byte write, nothing counts: no flag is raised and wave_out stays 1 in any mode, including after low-byte writes.
- R2: A write with wr_hi=0 only stores wr_data as the low byte, and the stored low byte persists across later loads. A write with wr_hi=1 loads the counter with {wr_data, stored low byte}, clears irq_flag and drives wave_out to 0 on the next cycle.
- R3: In one-shot mode (mode 2'b00, and also 2'b11), after a load of value N the time-out occurs on the (N+1)-th clock edge after the load edge. On that edge irq_flag and wave_out both become 1.
- R4: In one-shot and pulse-counting modes the flag is set at most once per load. After it is cleared, it stays 0 until the next high-byte write, even though the counter keeps decrementing and wraps around.
- R5: In free-running mode (mode 2'b01) the counter reloads from the latch on the edge after it holds 0, giving a time-out every N+1 cycles. Each time-out sets irq_flag and inverts wave_out.
- R6: In pulse-counting mode (mode 2'b10) the counter ignores the clock and decrements once per falling edge of pulse_in. The input passes through a two-flop synchroniser. After a load of N, N falling edges raise no flag, and the (N+1)-th falling edge sets irq_flag and wave_out to 1 within 3 clock edges. Rising edges do nothing.
- R7: irq_clr clears irq_flag on the next edge. If a time-out that sets the flag falls in the same cycle, the set wins. A high-byte write overrides both and leaves the flag at 0.
- R8: The synchronised falling-edge detector produces a pulse exactly one cycle long for each falling edge of pulse_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | 1 selects the high byte (load and start), 0 the low-byte latch |
| wr_data | input | 8 | Byte being written |
| mode | input | 2 | 00 one-shot, 01 free-running, 10 pulse counting, 11 one-shot |
| pulse_in | input | 1 | Asynchronous external count input |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Interrupt flag, set on time-out |
| wave_out | output | 1 | Single pulse or square wave output |

## Verification
The bench measures the delay from each load to the time-out for random start values. That includes a start value of 0, so a counter that fires on reaching zero instead of one tick later shows up as an off-by-one. In free-running mode it times consecutive wave edges, which exposes a reload that drops or adds a cycle or fails to toggle. It counts falling edges one at a time in pulse mode, so a design that counts rising edges, counts the clock, or double-counts a held-low input raises the flag at the wrong edge. It also re-checks the flag long after a one-shot time-out, where a design that re-arms on wrap-around sets it a second time.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    TM_ONESHOT = 2'b00,
    TM_FREERUN = 2'b01,
    TM_PULSE   = 2'b10,
    TM_ONESHOT2 = 2'b11
  } tmr_mode_e;

  function automatic logic mode_is_freerun(input logic [1:0] m);
    return m == TM_FREERUN;
  endfunction

  function automatic logic mode_is_pulse(input logic [1:0] m);
    return m == TM_PULSE;
  endfunction

  // next counter value: load beats reload beats decrement
  function automatic logic [15:0] cnt_next(
    input logic        do_load,
    input logic [15:0] load_val,
    input logic        do_reload,
    input logic [15:0] reload_val,
    input logic        do_tick,
    input logic [15:0] cur);
    if (do_load)        return load_val;
    else if (do_reload) return reload_val;
    else if (do_tick)   return cur - 16'd1;
    else                return cur;
  endfunction
endpackage

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[LEN-2:0], din};
  end

  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        mode,
  input  logic              fall,
  output logic              load,
  output logic              expire,
  output logic              freerun
);
  localparam int W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lat_lo, lat_hi;
  logic [W-1:0]      cnt;
  logic              started;
  logic              tick;

  assign load    = wr_en & wr_hi;
  assign freerun = mode_is_freerun(mode);
  assign tick    = started & (mode_is_pulse(mode) ? fall : 1'b1);
  assign expire  = tick & (cnt == '0) & ~load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_lo  <= '0;
      lat_hi  <= '0;
      cnt     <= '0;
      started <= 1'b0;
    end else begin
      if (wr_en && !wr_hi) lat_lo <= wr_data;
      if (load) begin
        lat_hi  <= wr_data;
        started <= 1'b1;
      end
      cnt <= cnt_next(load, {wr_data, lat_lo}, expire & freerun,
                      {lat_hi, lat_lo}, tick, cnt);
    end
  end
endmodule

// File: rtl/tmr16_outflag.sv
module tmr16_outflag (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic expire,
  input  logic freerun,
  input  logic irq_clr,
  output logic armed,
  output logic irq_flag,
  output logic wave_out
);
  logic flag_set;
  assign flag_set = expire & (freerun | armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      irq_flag <= 1'b0;
      wave_out <= 1'b1;
    end else begin
      if (load)        armed <= 1'b1;
      else if (expire) armed <= 1'b0;

      if (load)          irq_flag <= 1'b0;
      else if (flag_set) irq_flag <= 1'b1;
      else if (irq_clr)  irq_flag <= 1'b0;

      if (load)                  wave_out <= 1'b0;
      else if (expire & freerun) wave_out <= ~wave_out;
      else if (flag_set)         wave_out <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        mode,
  input  logic              pulse_in,
  input  logic              irq_clr,
  output logic              irq_flag,
  output logic              wave_out
);
  logic fall_w, load_w, expire_w, freerun_w, armed_w;

  tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pulse_in), .fall(fall_w));

  tmr16_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .mode(mode), .fall(fall_w),
    .load(load_w), .expire(expire_w), .freerun(freerun_w));

  tmr16_outflag u_out (
    .clk(clk), .rst_n(rst_n), .load(load_w), .expire(expire_w),
    .freerun(freerun_w), .irq_clr(irq_clr), .armed(armed_w),
    .irq_flag(irq_flag), .wave_out(wave_out));
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker (
  input logic clk,
  input logic rst_n,
  input logic load,
  input logic expire,
  input logic freerun,
  input logic armed,
  input logic fall,
  input logic irq_clr,
  input logic irq_flag,
  input logic wave_out
);
  a_r2_load_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !irq_flag);
  a_r2_load_wave_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !wave_out);
  a_r4_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !freerun && !armed && !irq_clr) |=> $stable(irq_flag));
  a_r5_wave_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && freerun) |=> (wave_out != $past(wave_out)));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !expire) |=> !irq_flag);
  a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(expire));
  a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

bind tmr16_counter tmr16_checker u_chk (
  .clk(clk), .rst_n(rst_n), .load(load_w), .expire(expire_w),
  .freerun(freerun_w), .armed(armed_w), .fall(fall_w),
  .irq_clr(irq_clr), .irq_flag(irq_flag), .wave_out(wave_out));

// File: tb/tmr16_counter_bench.sv
module tmr16_counter_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_hi = 0, pulse_in = 1, irq_clr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] mode = 0;
  logic irq_flag, wave_out;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  tmr16_counter u_tmr16_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .mode(mode), .pulse_in(pulse_in),
    .irq_clr(irq_clr), .irq_flag(irq_flag), .wave_out(wave_out));

  // expected delay from load edge to time-out edge for start value n
  function automatic int exp_timeout(input int n);
    return n + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic hi, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_hi = hi; wr_data = d;
    @(negedge clk); wr_en = 0; wr_hi = 0;
  endtask

  task automatic clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  // cycles until irq_flag (or wave change) seen, capped
  task automatic wait_flag(output int c);
    c = 0;
    while (!irq_flag && c < 70000) begin @(negedge clk); c++; end
  endtask

  task automatic wait_wave(input logic lvl, output int c);
    c = 0;
    while (wave_out != lvl && c < 70000) begin @(negedge clk); c++; end
  endtask

  task automatic pulse_fall();
    @(negedge clk); pulse_in = 0; idle(4);
    pulse_in = 1; idle(4);
  endtask

  initial begin
    idle(400000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c, n, seed;
    seed = $urandom(32'h5EED_0042);
    idle(3); rst_n = 1; idle(1);
    check("R1 flag after reset", irq_flag, 0);
    check("R1 wave after reset", wave_out, 1);

    // R1/R2: low-byte write alone starts nothing, even in free-run
    mode = 2'b01; wr(0, 8'd5); idle(30);
    check("R1 no flag before high write", irq_flag, 0);
    check("R1 wave idle before high write", wave_out, 1);

    // R3 one-shot, directed start 0 and reuse of stored low byte (R2)
    mode = 2'b00; wr(0, 8'd0); wr(1, 8'd0);
    check("R2 wave low after load", wave_out, 0);
    wait_flag(c); check("R3 one-shot N=0 timeout", c, exp_timeout(0));
    check("R3 wave high at timeout", wave_out, 1);
    wr(0, 8'd9); wr(1, 8'd0); wait_flag(c);
    check("R3 one-shot N=9", c, exp_timeout(9));
    wr(1, 8'd0); wait_flag(c);
    check("R2 low byte retained", c, exp_timeout(9));

    // R3 random one-shot values, mode 11 too
    for (int k = 0; k < 6; k++) begin
      n = $urandom_range(1, 300);
      mode = (k % 2 == 0) ? 2'b00 : 2'b11;
      wr(0, n[7:0]); wr(1, n[15:8]);
      wait_flag(c); check("R3 one-shot random", c, exp_timeout(n));
    end

    // R2 high write clears a set flag
    wr(1, 8'd0);
    check("R2 high write clears flag", irq_flag, 0);

    // R4: only one flag per load, even past wrap-around
    wr(0, 8'd2); wr(1, 8'd0); wait_flag(c); clr();
    check("R7 clear", irq_flag, 0);
    idle(65600);
    check("R4 no second flag", irq_flag, 0);
    check("R4 wave stays high", wave_out, 1);

    // R5 free-run: wave toggles every N+1, flag again after clear
    for (int k = 0; k < 4; k++) begin
      n = $urandom_range(6, 200);
      mode = 2'b01; wr(0, n[7:0]); wr(1, 8'd0);
      wait_wave(1, c); check("R5 first half period", c, exp_timeout(n));
      wait_wave(0, c); check("R5 second half period", c, exp_timeout(n));
      wait_wave(1, c); check("R5 third half period", c, exp_timeout(n));
      check("R5 flag set", irq_flag, 1);
      clr(); check("R7 clear in free-run", irq_flag, 0);
      wait_flag(c); check("R5 flag again", c > 0 && c <= n + 1, 1);
    end

    // R7: clear in the time-out cycle loses to the set
    mode = 2'b00; wr(0, 8'd3); wr(1, 8'd0);
    idle(3); irq_clr = 1; @(negedge clk); irq_clr = 0;
    check("R7 set wins over clear", irq_flag, 1);

    // R6 pulse counting
    for (int k = 0; k < 4; k++) begin
      n = $urandom_range(1, 12);
      mode = 2'b10; wr(0, n[7:0]); wr(1, 8'd0);
      idle(50);
      check("R6 clock not counted", irq_flag, 0);
      for (int e = 0; e < n; e++) pulse_fall();
      check("R6 no flag after N falls", irq_flag, 0);
      check("R6 wave low after N falls", wave_out, 0);
      @(negedge clk); pulse_in = 0;
      idle(3);
      check("R6 flag after N+1 falls", irq_flag, 1);
      check("R6 wave high after N+1 falls", wave_out, 1);
      pulse_in = 1; idle(4);
      clr(); pulse_fall(); pulse_fall();
      check("R4 pulse mode single flag", irq_flag, 0);
    end

    // R6 edge latency: flag not yet after 2 edges
    mode = 2'b10; wr(0, 8'd0); wr(1, 8'd0);
    @(negedge clk); pulse_in = 0; idle(2);
    check("R6 sync latency not early", irq_flag, 0);
    idle(1);
    check("R6 sync latency on time", irq_flag, 1);
    pulse_in = 1; idle(4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule